// File: doc/BRIEF.md
# Biphase Word Receiver

This block takes an incoming low-rate serial data line and turns it into 12-bit words. It handles three line codes. The first is a bipolar return-to-zero code carried on a pair of lines. The other two are biphase codes carried on a single line: biphase-space (FM0) and biphase-mark (FM1). The transmitter supplies no clock. The receiver samples the line on a strobe that runs at sixteen times the nominal bit rate, and it realigns its bit-cell timing on the transition that every cell guarantees. In the biphase modes that is the transition at the cell boundary; in return-to-zero mode it is the leading edge of the pulse.

Bits are gathered least significant bit first. In the biphase modes the receiver first hunts for a fixed 12-bit sync pattern, and words are delivered only after that pattern has been seen. In return-to-zero mode a quiet gap on the line marks the start of a word. Each completed word goes into a holding register. Software reads that register as a low-byte port and a high-byte port, whose upper nibble is always zero. A completed word raises an interrupt, and a read strobe on the high byte clears it. A status output reports sync in the biphase modes. Any coding violation on the line is pulsed on an error output.

Top module: `biphase_word_rx`

## Requirements
- R1: After reset, `irq`, `overrun` and `code_err` are 0, and `data_lo` and `data_hi` are all zeros.
- R2: In FM1 mode (`mode` = 3'b110), every cell starts with a level change, and a second change at mid-cell encodes a 1. Once the sync pattern 12'hB29 has been received (sent LSB first), each following group of 12 cells is delivered as one word, with the first bit received in bit 0. The sync pattern itself is never delivered.
- R3: In FM0 mode (`mode` = 3'b101), every cell starts with a level change, and a mid-cell change encodes a 0. Word delivery otherwise follows R2.
- R4: In return-to-zero mode (`mode` = 3'b100), a pulse on `rz_a` is a 1 and a pulse on `rz_b` is a 0. Every 12 pulses form a word. A gap of two bit periods with no pulse discards any partial word and starts a new one.
- R5: `irq` goes to 1 in the clock cycle after a word completes. A one-cycle `rd_hi` pulse clears it at the next clock edge.
- R6: `data_hi[7:4]` always reads 0, and `data_hi[3:0]` holds word bits 11..8.
- R7: In FM0 and FM1 modes, `sync_ok` is 1 only while word alignment is held. In every other mode it reads 1.
- R8: In FM mode, a cell-boundary transition that is missing for more than a cell and a fraction pulses `code_err` and drops alignment. No word is then delivered until the sync pattern is seen again.
- R9: A word that completes while `irq` is still 1 overwrites the held word and sets `overrun`. `overrun` stays at 1 until reset.
- R10: Any `mode` value other than 3'b100, 3'b101 or 3'b110 ignores all line inputs.
- R11: A cell stretched or shortened to between 14 and 18 oversample periods still decodes correctly, because the cell timing realigns on every boundary transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample strobe, 16 per nominal bit period |
| mode | input | 3 | Line code select (100 RZ, 101 FM0, 110 FM1) |
| fm_in | input | 1 | Biphase line input |
| rz_a | input | 1 | Return-to-zero line, pulse means 1 |
| rz_b | input | 1 | Return-to-zero line, pulse means 0 |
| rd_hi | input | 1 | Read strobe of the high byte, clears `irq` |
| data_lo | output | 8 | Held word bits 7..0 |
| data_hi | output | 8 | Zero nibble and held word bits 11..8 |
| irq | output | 1 | Word-ready interrupt |
| sync_ok | output | 1 | Alignment status in FM modes, 1 otherwise |
| overrun | output | 1 | Sticky flag: a word was lost |
| code_err | output | 1 | One-cycle pulse on a coding violation |

## Verification
The hardest state to reach is loss of alignment in the middle of a word, followed by a word that must then be rejected. The stimulus obtains sync, sends a few bits, and then holds the biphase line still for several cells so that the boundary watchdog fires. It then sends a full word without a sync pattern and confirms that `irq` stays low. Cell-length tolerance is reached by having the line driver alternate 14- and 18-period cells inside one word.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  localparam logic [2:0] MODE_RZ  = 3'b100;
  localparam logic [2:0] MODE_FM0 = 3'b101;
  localparam logic [2:0] MODE_FM1 = 3'b110;

  typedef enum logic [1:0] {POS_EARLY, POS_MID, POS_BOUND} edge_pos_e;

  function automatic logic is_fm(input logic [2:0] m);
    return (m == MODE_FM0) || (m == MODE_FM1);
  endfunction

  function automatic logic is_rz(input logic [2:0] m);
    return m == MODE_RZ;
  endfunction

  // mark coding: mid-cell change means 1; space coding: it means 0
  function automatic logic fm_bit(input logic mid_seen, input logic mark);
    return mark ? mid_seen : !mid_seen;
  endfunction

  // where an edge falls, k oversample periods after the last boundary
  function automatic edge_pos_e classify(input int unsigned k, input int unsigned osr);
    if (k < osr / 4) return POS_EARLY;
    else if (k < (3 * osr) / 4) return POS_MID;
    else return POS_BOUND;
  endfunction
endpackage

// File: rtl/bwr_line_sync.sv
module bwr_line_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/bwr_fm_cell.sv
module bwr_fm_cell
  import bwr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic clr,
  input  logic mark,
  input  logic line,
  output logic bit_vld,
  output logic bit_val,
  output logic err
);
  localparam int CW = $clog2(OSR + OSR / 4 + 2);
  localparam logic [CW-1:0] LOSS = CW'(OSR + OSR / 4);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;
  logic          prev, locked, mid;
  logic          edge_now;
  edge_pos_e     pos;

  assign edge_now = line != prev;
  assign pos      = classify(32'(cnt), OSR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0; cnt <= LOSS; locked <= 1'b0; mid <= 1'b0;
      bit_vld <= 1'b0; bit_val <= 1'b0; err <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      err     <= 1'b0;
      if (clr || !en) begin
        prev <= line; cnt <= LOSS; locked <= 1'b0; mid <= 1'b0;
      end else if (tick) begin
        prev <= line;
        if (edge_now && !locked) begin
          locked <= 1'b1; mid <= 1'b0; cnt <= ONE;
        end else if (edge_now) begin
          case (pos)
            POS_EARLY: begin
              err <= 1'b1; locked <= 1'b0; mid <= 1'b0; cnt <= ONE;
            end
            POS_MID: begin
              cnt <= cnt + ONE;
              if (mid) begin
                err <= 1'b1; locked <= 1'b0; mid <= 1'b0;
              end else begin
                mid <= 1'b1;
              end
            end
            default: begin
              bit_vld <= 1'b1;
              bit_val <= fm_bit(mid, mark);
              mid     <= 1'b0;
              cnt     <= ONE;
            end
          endcase
        end else begin
          if (cnt != LOSS) cnt <= cnt + ONE;
          if (locked && cnt == LOSS - ONE) begin
            err <= 1'b1; locked <= 1'b0; mid <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/bwr_rz_cell.sv
module bwr_rz_cell #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic clr,
  input  logic line_a,
  input  logic line_b,
  output logic bit_vld,
  output logic bit_val,
  output logic err,
  output logic restart
);
  localparam int GAP_N = 2 * OSR;
  localparam int CW    = $clog2(GAP_N + 1);
  localparam logic [CW-1:0] GAP = CW'(GAP_N);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] gap_cnt;
  logic          act, prev_act, rise;

  assign act  = line_a | line_b;
  assign rise = act && !prev_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= GAP; prev_act <= 1'b0;
      bit_vld <= 1'b0; bit_val <= 1'b0; err <= 1'b0; restart <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      err     <= 1'b0;
      restart <= 1'b0;
      if (clr || !en) begin
        prev_act <= act; gap_cnt <= GAP;
      end else if (tick) begin
        prev_act <= act;
        if (rise) begin
          gap_cnt <= ONE;
          if (line_a && line_b) err <= 1'b1;
          else begin
            bit_vld <= 1'b1;
            bit_val <= line_a;
          end
        end else begin
          if (gap_cnt != GAP) gap_cnt <= gap_cnt + ONE;
          if (gap_cnt == GAP - ONE) restart <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bwr_word_asm.sv
module bwr_word_asm #(
  parameter int          W    = 12,
  parameter logic [W-1:0] SYNC = 12'hB29
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         need_sync,
  input  logic         bit_vld,
  input  logic         bit_val,
  input  logic         err,
  input  logic         restart,
  input  logic         rd_hi,
  output logic [W-1:0] hold,
  output logic         ready,
  output logic         overrun,
  output logic         aligned,
  output logic         word_done
);
  localparam int CNTW = $clog2(W);
  localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

  logic [W-1:0]    sh, nxt_sh;
  logic [CNTW-1:0] cnt;
  logic            in_word;

  assign nxt_sh    = {bit_val, sh[W-1:1]};
  assign in_word   = aligned || !need_sync;
  assign word_done = bit_vld && !clr && !err && in_word && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; aligned <= 1'b0;
    end else if (clr) begin
      sh <= '0; cnt <= '0; aligned <= 1'b0;
    end else if (err) begin
      cnt <= '0; aligned <= 1'b0;
    end else if (restart) begin
      cnt <= '0;
    end else if (bit_vld) begin
      sh <= nxt_sh;
      if (!in_word) begin
        if (nxt_sh == SYNC) begin
          aligned <= 1'b1;
          cnt     <= '0;
        end
      end else if (cnt == LAST) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0; ready <= 1'b0; overrun <= 1'b0;
    end else if (word_done) begin
      hold  <= nxt_sh;
      ready <= 1'b1;
      if (ready && !rd_hi) overrun <= 1'b1;
    end else if (rd_hi) begin
      ready <= 1'b0;
    end
  end
endmodule

// File: rtl/biphase_word_rx.sv
module biphase_word_rx
  import bwr_pkg::*;
#(
  parameter int           OSR  = 16,
  parameter int           W    = 12,
  parameter logic [W-1:0] SYNC = 12'hB29
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic [2:0] mode,
  input  logic       fm_in,
  input  logic       rz_a,
  input  logic       rz_b,
  input  logic       rd_hi,
  output logic [7:0] data_lo,
  output logic [7:0] data_hi,
  output logic       irq,
  output logic       sync_ok,
  output logic       overrun,
  output logic       code_err
);
  localparam int HI_PAD = 16 - W;

  logic [2:0]   lines_s;
  logic [2:0]   mode_q;
  logic         mode_chg, fm_en, rz_en;
  logic         fm_vld, fm_val, fm_err;
  logic         rz_vld, rz_val, rz_err, rz_restart;
  logic         bit_vld, bit_val, any_err;
  logic         aligned, word_done;
  logic [W-1:0] hold;

  bwr_line_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({rz_b, rz_a, fm_in}), .q(lines_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 3'b000;
    else        mode_q <= mode;
  end

  assign mode_chg = mode != mode_q;
  assign fm_en    = is_fm(mode);
  assign rz_en    = is_rz(mode);

  bwr_fm_cell #(.OSR(OSR)) u_fm (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .en(fm_en), .clr(mode_chg),
    .mark(mode == MODE_FM1), .line(lines_s[0]),
    .bit_vld(fm_vld), .bit_val(fm_val), .err(fm_err)
  );

  bwr_rz_cell #(.OSR(OSR)) u_rz (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .en(rz_en), .clr(mode_chg),
    .line_a(lines_s[1]), .line_b(lines_s[2]),
    .bit_vld(rz_vld), .bit_val(rz_val), .err(rz_err), .restart(rz_restart)
  );

  assign bit_vld = fm_vld | rz_vld;
  assign bit_val = fm_vld ? fm_val : rz_val;
  assign any_err = fm_err | rz_err;

  bwr_word_asm #(.W(W), .SYNC(SYNC)) u_asm (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .need_sync(fm_en),
    .bit_vld(bit_vld), .bit_val(bit_val), .err(any_err), .restart(rz_restart),
    .rd_hi(rd_hi), .hold(hold), .ready(irq), .overrun(overrun),
    .aligned(aligned), .word_done(word_done)
  );

  assign data_lo  = hold[7:0];
  assign data_hi  = {{HI_PAD{1'b0}}, hold[W-1:8]};
  assign sync_ok  = fm_en ? aligned : 1'b1;
  assign code_err = any_err;
endmodule

// File: rtl/bwr_chk.sv
module bwr_chk
  import bwr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       rd_hi,
  input logic       irq,
  input logic       sync_ok,
  input logic       overrun,
  input logic [7:0] data_hi,
  input logic       code_err,
  input logic       word_done,
  input logic       fm_en
);
  assert_irq_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> irq);
  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !word_done) |=> !irq);
  assert_hi_nibble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_hi[7:4] == 4'h0);
  assert_sync_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fm_en |-> sync_ok);
  assert_loss_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_err && fm_en) |=> (!sync_ok || !fm_en));
  assert_ovr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && irq && !rd_hi) |=> overrun);
  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_fm(mode) || is_rz(mode)) |-> !word_done);
endmodule

bind biphase_word_rx bwr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .rd_hi(rd_hi), .irq(irq),
  .sync_ok(sync_ok), .overrun(overrun), .data_hi(data_hi),
  .code_err(code_err), .word_done(word_done), .fm_en(fm_en)
);

// File: tb/sim_biphase_word_rx.sv
module sim_biphase_word_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b1;
  logic [2:0] mode = 3'b000;
  logic       fm_in = 1'b0, rz_a = 1'b0, rz_b = 1'b0, rd_hi = 1'b0;
  logic [7:0] data_lo, data_hi;
  logic       irq, sync_ok, overrun, code_err;

  int n_tests = 0, n_fail = 0, err_cnt = 0;
  localparam logic [11:0] SYNC_W = 12'hB29;

  always #10 clk = ~clk;

  biphase_word_rx u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .mode(mode), .fm_in(fm_in),
    .rz_a(rz_a), .rz_b(rz_b), .rd_hi(rd_hi), .data_lo(data_lo), .data_hi(data_hi),
    .irq(irq), .sync_ok(sync_ok), .overrun(overrun), .code_err(code_err)
  );

  always @(posedge clk) if (code_err) err_cnt <= err_cnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fm_cell(input bit b, input bit mark, input int len);
    fm_in = ~fm_in;
    if (mark ? b : !b) begin
      ticks(len / 2);
      fm_in = ~fm_in;
      ticks(len - len / 2);
    end else ticks(len);
  endtask

  task automatic fm_word(input logic [11:0] w, input bit mark, input int len);
    for (int i = 0; i < 12; i++) fm_cell(w[i], mark, len);
  endtask

  task automatic fm_start(input bit mark);
    for (int i = 0; i < 3; i++) fm_cell(1'b0, mark, 16);
    fm_word(SYNC_W, mark, 16);
  endtask

  task automatic rz_cell(input bit b);
    if (b) rz_a = 1'b1; else rz_b = 1'b1;
    ticks(8);
    rz_a = 1'b0; rz_b = 1'b0;
    ticks(8);
  endtask

  task automatic wait_irq(output bit got, input int lim);
    got = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (irq) begin got = 1'b1; break; end
    end
  endtask

  task automatic read_word(output logic [11:0] w);
    w = {data_hi[3:0], data_lo};
    rd_hi = 1'b1;
    @(negedge clk);
    rd_hi = 1'b0;
  endtask

  task automatic t_reset;
    ticks(3);
    check(irq == 1'b0 && overrun == 1'b0 && code_err == 1'b0, "R1 flags", {irq, overrun, code_err}, 0);
    check(data_lo == 8'h00 && data_hi == 8'h00, "R1 data", {data_hi, data_lo}, 0);
    rst_n = 1'b1;
    ticks(2);
    check(irq == 1'b0 && sync_ok == 1'b1, "R1/R7 after reset", {irq, sync_ok}, 1);
  endtask

  task automatic t_fm1;
    logic [11:0] w; bit got;
    mode = 3'b110; ticks(4);
    fm_start(1'b1);
    fm_word(12'h3A5, 1'b1, 16);
    fm_cell(1'b0, 1'b1, 16);
    check(sync_ok == 1'b1, "R7 aligned FM1", sync_ok, 1);
    wait_irq(got, 40);
    check(got, "R2 irq FM1", got, 1);
    check(data_hi[7:4] == 4'h0, "R6 upper nibble", data_hi, 0);
    read_word(w);
    check(w == 12'h3A5, "R2 FM1 word", w, 12'h3A5);
    check(irq == 1'b0, "R5 irq cleared", irq, 0);
  endtask

  task automatic t_fm0;
    logic [11:0] w; bit got;
    mode = 3'b101; ticks(4);
    fm_start(1'b0);
    fm_word(12'hC5E, 1'b0, 16);
    fm_cell(1'b1, 1'b0, 16);
    wait_irq(got, 40);
    read_word(w);
    check(got && w == 12'hC5E, "R3 FM0 word", w, 12'hC5E);
    check(w[11:8] == 4'hC, "R6 high nibble", w[11:8], 4'hC);
  endtask

  task automatic t_jitter;
    logic [11:0] w; bit got;
    logic [11:0] v = 12'h71D;
    mode = 3'b110; ticks(4);
    fm_start(1'b1);
    for (int i = 0; i < 12; i++) fm_cell(v[i], 1'b1, (i % 2 == 0) ? 14 : 18);
    fm_cell(1'b0, 1'b1, 14);
    wait_irq(got, 40);
    read_word(w);
    check(got && w == v, "R11 stretched cells", w, v);
  endtask

  task automatic t_loss;
    bit got; int e0;
    mode = 3'b110; ticks(4);
    fm_start(1'b1);
    for (int i = 0; i < 5; i++) fm_cell(i[0], 1'b1, 16);
    e0 = err_cnt;
    ticks(48);
    check(err_cnt > e0, "R8 code_err pulse", err_cnt - e0, 1);
    check(sync_ok == 1'b0, "R8/R7 alignment dropped", sync_ok, 0);
    fm_word(12'h6D3, 1'b1, 16);
    fm_cell(1'b0, 1'b1, 16);
    wait_irq(got, 40);
    check(!got, "R8 no word without sync", got, 0);
  endtask

  task automatic t_rz;
    logic [11:0] w; bit got;
    logic [11:0] v = 12'h9B4;
    mode = 3'b100; ticks(4);
    rz_cell(1); rz_cell(0); rz_cell(1); rz_cell(1); rz_cell(0);
    ticks(48);
    for (int i = 0; i < 12; i++) rz_cell(v[i]);
    wait_irq(got, 40);
    check(sync_ok == 1'b1, "R7 RZ reads one", sync_ok, 1);
    read_word(w);
    check(got && w == v, "R4 RZ word after gap", w, v);
  endtask

  task automatic t_off;
    bit got;
    mode = 3'b000; ticks(4);
    for (int i = 0; i < 3; i++) fm_cell(1'b0, 1'b1, 16);
    fm_word(SYNC_W, 1'b1, 16);
    fm_word(12'h155, 1'b1, 16);
    for (int i = 0; i < 14; i++) rz_cell(i[0]);
    wait_irq(got, 40);
    check(!got && sync_ok == 1'b1, "R10 off mode ignores lines", {got, sync_ok}, 1);
  endtask

  task automatic t_ovr;
    logic [11:0] w; bit got;
    check(overrun == 1'b0, "R9 no overrun yet", overrun, 0);
    mode = 3'b110; ticks(4);
    fm_start(1'b1);
    fm_word(12'h0A1, 1'b1, 16);
    fm_word(12'hF3C, 1'b1, 16);
    fm_cell(1'b0, 1'b1, 16);
    wait_irq(got, 40);
    check(overrun == 1'b1, "R9 overrun set", overrun, 1);
    read_word(w);
    check(got && w == 12'hF3C, "R9 newer word kept", w, 12'hF3C);
    ticks(2);
    check(overrun == 1'b1 && irq == 1'b0, "R9 overrun sticky", {overrun, irq}, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fm1();
    t_fm0();
    t_jitter();
    t_loss();
    t_rz();
    t_off();
    t_ovr();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule